// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects interrupt events for a small CPU and turns them into one vectored request at a time. There are seven vectors. Vector 0 is shared by an internal periodic tick and a both-edge external pin. Vectors 1 and 2 come from two external pins whose active edge is chosen per pin; the first of those pins passes through a sampled noise filter. Vectors 3 to 6 come from a serial-transfer-done pulse, a timer-match pulse, a falling edge on the chip-enable pin and an IF-gate-close pulse. Two further "quasi" flags are kept, one for a key-scan wake event and one for a watch-timer tick. They are never vectored, and only software clears them.

A request is granted when its flag, its per-vector enable and the master enable are all set, and the current nesting level allows it. A 3-bit priority field either leaves the default order in force or lifts one vector above all the others. On a grant the controller pulses `take_o` with the vector index, clears the flag in hardware (except for the shared vector 0), and moves to the next nesting level. A return strobe restores the previous level. Any new flag setting pulses a wake output whatever the enables are, so a power-down state can be left.

Top module: `vect_irq_ctrl`

## Requirements
- R1: While reset is held and right after it, `req_o`, `take_o`, `nest_o` and `wake_o` are all zero.
- R2: Vector indices follow default priority: 0 = tick/pin4, 1 = pin0, 2 = pin1, 3 = serial, 4 = timer match, 5 = CE fall, 6 = gate close. If several are eligible together, the lowest index is granted and the rest keep their flags.
- R3: With `prio_i` = 0 the default order applies. A value p from 1 to 7 makes vector p-1 the one high-priority vector, and it wins over every other eligible vector.
- R4: A vector is granted only when its flag, `en_i[v]` and `ime_i` are all 1. A flag that is not enabled stays set until it is enabled.
- R5: `nest_o` is 00 at base, 01 after a low-priority grant and 10 after a high-priority grant. At 00 any eligible vector is granted. At 01 only the high-priority vector is granted. At 10 nothing is granted. Each `ret_i` pulse restores the level held before the last grant, and `ret_i` at 00 leaves it at 00.
- R6: `req_o` bits are: 0 tick, 1 pin4, 2 pin0, 3 pin1, 4 serial, 5 timer, 6 CE, 7 gate, 8 key, 9 watch. A grant clears the flag of vectors 1 to 6. Flags 0 and 1 stay set when vector 0 is granted. Flags 8 and 9 are never vectored and clear only through `clr_i`. A `clr_i` bit clears its flag. A new event in the same cycle wins over a clear.
- R7: pin4 sets its flag on both edges. pin0 and pin1 set theirs on a rising edge when `edge_sel_i` bit 0 or bit 1 (respectively) is 1, and on a falling edge when it is 0. A CE falling edge sets flag 6.
- R8: pin0 is sampled every FILT_DIV cycles. A pulse shorter than FILT_DIV cycles is rejected, and a level held for at least 2*FILT_DIV cycles is accepted.
- R9: The key flag sets on a rising edge of pin2, or when the AND of all key inputs falls. So no key edge is seen while another key input is already low.
- R10: `wake_o` pulses in the cycle after any flag goes from 0 to 1, whatever `ime_i` and `en_i` are.
- R11: `take_o` is a one-cycle strobe per grant with `vec_o` valid alongside it. No grant is made in a cycle where `ret_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_int0_i | input | 1 | Filtered external pin, edge selectable |
| pin_int1_i | input | 1 | External pin, edge selectable |
| pin_int2_i | input | 1 | Key-wake pin, rising edge |
| pin_int4_i | input | 1 | External pin, both edges |
| key_i | input | NKEY | Key-scan inputs, falling edge |
| ce_i | input | 1 | Chip-enable pin, falling edge requests |
| tick_i | input | 1 | Periodic tick pulse (vector 0) |
| sio_done_i | input | 1 | Serial transfer done pulse |
| tmr_match_i | input | 1 | Timer match pulse |
| gate_close_i | input | 1 | IF gate close pulse |
| watch_i | input | 1 | Watch-timer pulse (quasi flag) |
| edge_sel_i | input | 2 | Edge select for pin0 (bit 0) and pin1 (bit 1) |
| en_i | input | 7 | Per-vector enables |
| ime_i | input | 1 | Master enable |
| prio_i | input | 3 | High-priority vector select |
| clr_i | input | 10 | Software flag clear mask |
| ret_i | input | 1 | Return-from-service strobe |
| take_o | output | 1 | Grant strobe |
| vec_o | output | 3 | Granted vector index |
| nest_o | output | 2 | Current nesting level |
| req_o | output | 10 | Request flags |
| wake_o | output | 1 | Power-down release pulse |

## Verification
A pulse on an internal source sets its flag at the next rising edge. A pin change is seen at the third rising edge after it, after two synchronizer stages and the edge register, and pin0 also waits for two filter samples. A grant strobe follows one edge after the flag, enable and level allow it. A return strobe changes `nest_o` at the next edge, and any grant comes one edge after that. The bench drives on falling edges and samples on falling edges after the counted rising edges. For pin events it waits a few cycles beyond the due edge, and a "no event" check waits long enough that a late flag would have shown up.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NVEC = 7;
  localparam int NREQ = 10;
  localparam int VW   = $clog2(NVEC);

  typedef enum logic [1:0] {
    NEST_BASE = 2'b00,
    NEST_LOW  = 2'b01,
    NEST_HIGH = 2'b10
  } nest_t;

  // request flag positions
  localparam int F_TICK  = 0;
  localparam int F_P4    = 1;
  localparam int F_P0    = 2;
  localparam int F_P1    = 3;
  localparam int F_SIO   = 4;
  localparam int F_TMR   = 5;
  localparam int F_CE    = 6;
  localparam int F_GATE  = 7;
  localparam int F_KEY   = 8;
  localparam int F_WATCH = 9;

  // fold request flags into per-vector pending bits
  function automatic logic [NVEC-1:0] vec_pend(input logic [NREQ-1:0] f);
    vec_pend = {f[F_GATE], f[F_CE], f[F_TMR], f[F_SIO], f[F_P1], f[F_P0],
                f[F_TICK] | f[F_P4]};
  endfunction
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/irqc_glitch.sv
module irqc_glitch #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    hist_q, hist_d;
  logic          out_q, out_d;
  logic          tick;

  always_comb begin
    tick   = (cnt_q == CW'(DIV - 1));
    cnt_d  = tick ? '0 : cnt_q + 1'b1;
    hist_d = hist_q;
    out_d  = out_q;
    if (tick) begin
      hist_d = {hist_q[0], din};
      if (hist_d[1] == hist_d[0]) out_d = hist_d[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hist_q <= '0;
      out_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      hist_q <= hist_d;
      out_q  <= out_d;
    end
  end

  assign dout = out_q;

  // R8: filtered level moves only on a sample edge
  a_r8_change_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> $past(tick));
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick
  import irqc_pkg::*;
(
  input  logic [NVEC-1:0] pend,
  input  logic [VW-1:0]   prio,
  input  nest_t           nest,
  output logic            grant,
  output logic [VW-1:0]   gidx,
  output logic            ghigh
);
  logic            hi_valid;
  logic [VW-1:0]   hidx;
  logic [NVEC-1:0] allow;

  always_comb begin
    hi_valid = (prio != '0);
    hidx     = prio - 1'b1;
    allow    = '0;
    unique case (nest)
      NEST_BASE: allow = pend;
      NEST_LOW:  if (hi_valid) allow = pend & (NVEC'(1) << hidx);
      default:   allow = '0;
    endcase
    grant = |allow;
    gidx  = '0;
    ghigh = 1'b0;
    for (int i = NVEC - 1; i >= 0; i--) begin
      if (allow[i]) gidx = VW'(i);
    end
    if (hi_valid && allow[hidx]) begin
      gidx  = hidx;
      ghigh = 1'b1;
    end
  end
endmodule

// File: rtl/vect_irq_ctrl.sv
module vect_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_DIV    = 8,
  parameter int NKEY        = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pin_int0_i,
  input  logic            pin_int1_i,
  input  logic            pin_int2_i,
  input  logic            pin_int4_i,
  input  logic [NKEY-1:0] key_i,
  input  logic            ce_i,
  input  logic            tick_i,
  input  logic            sio_done_i,
  input  logic            tmr_match_i,
  input  logic            gate_close_i,
  input  logic            watch_i,
  input  logic [1:0]      edge_sel_i,
  input  logic [NVEC-1:0] en_i,
  input  logic            ime_i,
  input  logic [VW-1:0]   prio_i,
  input  logic [NREQ-1:0] clr_i,
  input  logic            ret_i,
  output logic            take_o,
  output logic [VW-1:0]   vec_o,
  output logic [1:0]      nest_o,
  output logic [NREQ-1:0] req_o,
  output logic            wake_o
);
  localparam int P_I0   = 0;
  localparam int P_I1   = 1;
  localparam int P_I2   = 2;
  localparam int P_I4   = 3;
  localparam int P_CE   = 4;
  localparam int P_KEY  = 5;
  localparam int NPIN   = P_KEY + NKEY;
  localparam int STK    = 2;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_q;
  irqc_sync #(.W(1), .STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_q));

  // pin synchronizers
  logic [NPIN-1:0] pin_s;
  irqc_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_pins (
    .clk(clk), .rst_n(rst_q),
    .d({key_i, ce_i, pin_int4_i, pin_int2_i, pin_int1_i, pin_int0_i}),
    .q(pin_s));

  logic p0_flt;
  irqc_glitch #(.DIV(FILT_DIV)) u_flt (
    .clk(clk), .rst_n(rst_q), .din(pin_s[P_I0]), .dout(p0_flt));

  // state
  logic [NPIN-1:1] prev_q;
  logic            flt_prev_q;
  logic [NREQ-1:0] req_q, req_d;
  logic            wake_q, wake_d;
  logic            take_q, take_d;
  logic [VW-1:0]   vec_q, vec_d;
  nest_t           nest_q, nest_d;
  nest_t           stk_q [STK];
  nest_t           stk_d [STK];

  // edge events
  logic [NREQ-1:0] set_ev;
  logic            keys_now, keys_was;

  always_comb begin
    keys_now = &pin_s[NPIN-1:P_KEY];
    keys_was = &prev_q[NPIN-1:P_KEY];
    set_ev = '0;
    set_ev[F_TICK]  = tick_i;
    set_ev[F_P4]    = pin_s[P_I4] ^ prev_q[P_I4];
    set_ev[F_P0]    = edge_sel_i[0] ? (p0_flt & ~flt_prev_q) : (~p0_flt & flt_prev_q);
    set_ev[F_P1]    = edge_sel_i[1] ? (pin_s[P_I1] & ~prev_q[P_I1])
                                    : (~pin_s[P_I1] & prev_q[P_I1]);
    set_ev[F_SIO]   = sio_done_i;
    set_ev[F_TMR]   = tmr_match_i;
    set_ev[F_CE]    = ~pin_s[P_CE] & prev_q[P_CE];
    set_ev[F_GATE]  = gate_close_i;
    set_ev[F_KEY]   = (pin_s[P_I2] & ~prev_q[P_I2]) | (keys_was & ~keys_now);
    set_ev[F_WATCH] = watch_i;
  end

  // arbitration
  logic [NVEC-1:0] pend;
  logic            grant, ghigh, do_take;
  logic [VW-1:0]   gidx;

  assign pend = vec_pend(req_q) & en_i & {NVEC{ime_i}};

  irqc_pick u_pick (
    .pend(pend), .prio(prio_i), .nest(nest_q),
    .grant(grant), .gidx(gidx), .ghigh(ghigh));

  assign do_take = grant & ~ret_i;

  // next state
  logic [NREQ-1:0] hw_clr;

  always_comb begin
    hw_clr = '0;
    for (int v = 1; v < NVEC; v++) begin
      if (do_take && gidx == VW'(v)) hw_clr[v+1] = 1'b1;
    end
    req_d  = (req_q & ~clr_i & ~hw_clr) | set_ev;
    wake_d = |(set_ev & ~req_q);
    take_d = do_take;
    vec_d  = do_take ? gidx : vec_q;
    nest_d = nest_q;
    for (int i = 0; i < STK; i++) stk_d[i] = stk_q[i];
    if (do_take) begin
      nest_d   = ghigh ? NEST_HIGH : NEST_LOW;
      stk_d[0] = nest_q;
      for (int i = 1; i < STK; i++) stk_d[i] = stk_q[i-1];
    end else if (ret_i && nest_q != NEST_BASE) begin
      nest_d = stk_q[0];
      for (int i = 0; i < STK - 1; i++) stk_d[i] = stk_q[i+1];
      stk_d[STK-1] = NEST_BASE;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      prev_q     <= '0;
      flt_prev_q <= 1'b0;
      req_q      <= '0;
      wake_q     <= 1'b0;
      take_q     <= 1'b0;
      vec_q      <= '0;
      nest_q     <= NEST_BASE;
      for (int i = 0; i < STK; i++) stk_q[i] <= NEST_BASE;
    end else begin
      prev_q     <= pin_s[NPIN-1:1];
      flt_prev_q <= p0_flt;
      req_q      <= req_d;
      wake_q     <= wake_d;
      take_q     <= take_d;
      vec_q      <= vec_d;
      nest_q     <= nest_d;
      for (int i = 0; i < STK; i++) stk_q[i] <= stk_d[i];
    end
  end

  assign take_o = take_q;
  assign vec_o  = vec_q;
  assign nest_o = nest_q;
  assign req_o  = req_q;
  assign wake_o = wake_q;

  // R4: a grant needs master enable and the vector's enable
  a_r4_enabled_grant: assert property (@(posedge clk) disable iff (!rst_q)
    take_o |-> ($past(ime_i) && (($past(en_i) & (NVEC'(1) << vec_o)) != '0)));

  // R5: top level blocks all grants
  a_r5_top_blocks: assert property (@(posedge clk) disable iff (!rst_q)
    take_o |-> ($past(nest_o) != 2'b10));

  // R5: every grant leaves the base level
  a_r5_grant_nests: assert property (@(posedge clk) disable iff (!rst_q)
    take_o |-> (nest_o != 2'b00));

  // R5: only three legal levels
  a_r5_legal_level: assert property (@(posedge clk) disable iff (!rst_q)
    nest_o != 2'b11);

  // R11: no grant in a return cycle
  a_r11_ret_no_take: assert property (@(posedge clk) disable iff (!rst_q)
    $past(ret_i) |-> !take_o);

  // R10: a newly set flag comes with a wake pulse
  a_r10_wake_on_set: assert property (@(posedge clk) disable iff (!rst_q)
    (|(req_o & ~$past(req_o))) |-> wake_o);

  // R6: quasi flags survive unless software clears them
  a_r6_key_held: assert property (@(posedge clk) disable iff (!rst_q)
    (req_o[F_KEY] && !clr_i[F_KEY]) |=> req_o[F_KEY]);

  a_r6_watch_held: assert property (@(posedge clk) disable iff (!rst_q)
    (req_o[F_WATCH] && !clr_i[F_WATCH]) |=> req_o[F_WATCH]);
endmodule

// File: tb/test_vect_irq_ctrl.sv
`timescale 1ns/1ps
module test_vect_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pin0, pin1, pin2, pin4, ce;
  logic [3:0] keys;
  logic       tick, sio, tmr, gate, watch;
  logic [1:0] esel;
  logic [6:0] en;
  logic       ime;
  logic [2:0] prio;
  logic [9:0] clr;
  logic       ret;
  logic       take_o, wake_o;
  logic [2:0] vec_o;
  logic [1:0] nest_o;
  logic [9:0] req_o;

  int n_chk = 0;
  int n_fail = 0;
  int take_cnt = 0;
  int wake_cnt = 0;

  always #2.5 clk = ~clk;

  vect_irq_ctrl i_vect_irq_ctrl (
    .clk(clk), .rst_n(rst_n),
    .pin_int0_i(pin0), .pin_int1_i(pin1), .pin_int2_i(pin2), .pin_int4_i(pin4),
    .key_i(keys), .ce_i(ce),
    .tick_i(tick), .sio_done_i(sio), .tmr_match_i(tmr), .gate_close_i(gate),
    .watch_i(watch), .edge_sel_i(esel), .en_i(en), .ime_i(ime), .prio_i(prio),
    .clr_i(clr), .ret_i(ret),
    .take_o(take_o), .vec_o(vec_o), .nest_o(nest_o), .req_o(req_o), .wake_o(wake_o));

  always @(posedge clk) begin
    #1;
    if (take_o) take_cnt++;
    if (wake_o) wake_cnt++;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // expected grant from the requirements; -1 when none
  function automatic int model_pick(input logic [9:0] f, input logic [6:0] e,
                                    input logic [2:0] pr, input logic [1:0] ns);
    logic [6:0] p;
    int h;
    p[0] = f[0] | f[1];
    for (int v = 1; v < 7; v++) p[v] = f[v+1];
    p = p & e;
    h = (pr == 3'd0) ? -1 : int'(pr) - 1;
    if (ns == 2'b10) return -1;
    if (ns == 2'b01) return (h >= 0 && p[h]) ? h : -1;
    if (h >= 0 && p[h]) return h;
    for (int v = 0; v < 7; v++) if (p[v]) return v;
    return -1;
  endfunction

  task automatic tidy();
    ime = 1'b0; clr = 10'h3FF; ret = 1'b1;
    step(2);
    clr = '0; ret = 1'b0;
    step(1);
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int w0, t0, exp_v, h;
    logic [9:0] mf;
    logic [1:0] mn;
    void'($urandom(32'd4711));
    rst_n = 1'b0; pin0 = 0; pin1 = 0; pin2 = 0; pin4 = 0; ce = 1; keys = 4'hF;
    tick = 0; sio = 0; tmr = 0; gate = 0; watch = 0; esel = 2'b00;
    en = '0; ime = 0; prio = 0; clr = '0; ret = 0;
    step(4);
    // R1 reset state
    chk("R1 req", req_o, 0); chk("R1 take", take_o, 0);
    chk("R1 nest", nest_o, 0); chk("R1 wake", wake_o, 0);
    rst_n = 1'b1;
    step(6);
    chk("R1 req after release", req_o, 0);
    chk("R1 no wake after release", wake_cnt, 0);

    // R7 both edges on pin4, R10 wake
    pin4 = 1; step(5);
    chk("R7 pin4 rise", req_o[1], 1);
    chk("R10 wake count", wake_cnt, 1);
    clr = 10'h002; step(1); clr = '0;
    chk("R6 sw clear", req_o[1], 0);
    pin4 = 0; step(5);
    chk("R7 pin4 fall", req_o[1], 1);
    tidy();

    // R7 pin1 edge select
    esel = 2'b10; pin1 = 1; step(5);
    chk("R7 pin1 rise selected", req_o[3], 1);
    tidy();
    pin1 = 0; step(6);
    chk("R7 pin1 fall ignored", req_o[3], 0);
    esel = 2'b00; pin1 = 1; step(6);
    chk("R7 pin1 rise ignored", req_o[3], 0);
    pin1 = 0; step(5);
    chk("R7 pin1 fall selected", req_o[3], 1);
    tidy();

    // R8 noise filter on pin0 (FILT_DIV = 8)
    esel = 2'b01; pin0 = 1; step(5); pin0 = 0; step(40);
    chk("R8 narrow pulse rejected", req_o[2], 0);
    pin0 = 1; step(30);
    chk("R8 wide pulse accepted", req_o[2], 1);
    pin0 = 0; step(40);
    tidy();

    // R9 key flag
    keys = 4'b1011; step(5);
    chk("R9 key fall", req_o[8], 1);
    tidy();
    keys = 4'b1010; step(6);
    chk("R9 key blocked while other low", req_o[8], 0);
    keys = 4'hF; step(6);
    chk("R9 key release no event", req_o[8], 0);
    pin2 = 1; step(5);
    chk("R9 pin2 rise", req_o[8], 1);
    tidy(); pin2 = 0; step(5);

    // R7 CE falling
    ce = 0; step(5);
    chk("R7 ce fall", req_o[6], 1);
    ce = 1; step(5); tidy();

    // R6 quasi flag never vectored
    watch = 1; step(1); watch = 0;
    chk("R6 watch set", req_o[9], 1);
    t0 = take_cnt; en = 7'h7F; ime = 1; step(4);
    chk("R6 quasi not vectored", take_cnt - t0, 0);
    chk("R6 watch held", req_o[9], 1);
    tidy();

    // R4 pending held until enabled
    en = 7'h00; prio = 0;
    sio = 1; step(1); sio = 0; ime = 1; step(3);
    chk("R4 no take without enable", take_cnt - t0, 0);
    chk("R4 flag held", req_o[4], 1);
    en = 7'h08; step(1);
    chk("R4 take once enabled", take_o, 1);
    chk("R4 vec", vec_o, 3);
    chk("R6 hw clear", req_o[4], 0);
    tidy();

    // R6 shared vector keeps flag; R5 return restores
    en = 7'h7F; prio = 0;
    tick = 1; step(1); tick = 0; ime = 1; step(1);
    chk("R11 take strobe", take_o, 1);
    chk("R2 vec 0", vec_o, 0);
    chk("R6 shared flag kept", req_o[0], 1);
    chk("R5 low level", nest_o, 1);
    step(1);
    chk("R5 no low at 01", take_o, 0);
    ret = 1; step(1); ret = 0;
    chk("R11 no take on ret", take_o, 0);
    chk("R5 ret to base", nest_o, 0);
    step(1);
    chk("R6 shared retaken", take_o, 1);
    tidy();

    // R2 simultaneous requests
    en = 7'h7F; prio = 0;
    sio = 1; gate = 1; step(1); sio = 0; gate = 0; ime = 1; step(1);
    chk("R2 lower index wins", vec_o, 3);
    chk("R2 other pending", req_o[7], 1);
    tidy();

    // R3/R5 nesting with promoted timer (prio 5 -> vector 4)
    en = 7'h7F; prio = 3'd5;
    sio = 1; step(1); sio = 0; ime = 1; step(1);
    chk("R5 low take", vec_o, 3);
    gate = 1; step(1); gate = 0; step(1);
    chk("R5 low blocked at 01", take_o, 0);
    tmr = 1; step(1); tmr = 0; step(1);
    chk("R3 high preempts", take_o, 1);
    chk("R3 high vec", vec_o, 4);
    chk("R5 high level", nest_o, 2);
    step(1);
    chk("R5 nothing at 10", take_o, 0);
    ret = 1; step(1); ret = 0; step(1);
    chk("R5 ret to 01", nest_o, 1);
    chk("R5 gate still waiting", take_o, 0);
    ret = 1; step(1); ret = 0; step(1);
    chk("R5 gate after base", take_o, 1);
    chk("R5 gate vec", vec_o, 6);
    tidy();

    // random arbitration (R2, R3, R4, R5)
    for (int it = 0; it < 60; it++) begin
      logic [3:0] r;
      r = 4'($urandom);
      en = 7'($urandom); prio = 3'($urandom);
      tick = r[0]; sio = r[1]; tmr = r[2]; gate = r[3];
      step(1);
      tick = 0; sio = 0; tmr = 0; gate = 0;
      mf = '0; mf[0] = r[0]; mf[4] = r[1]; mf[5] = r[2]; mf[7] = r[3];
      chk("R6 random flags", req_o, mf);
      mn = 2'b00;
      h = (prio == 0) ? -1 : int'(prio) - 1;
      ime = 1; step(1);
      exp_v = model_pick(mf, en, prio, mn);
      chk("R3 random take", take_o, (exp_v >= 0) ? 1 : 0);
      if (exp_v >= 0) begin
        chk("R3 random vec", vec_o, exp_v);
        mn = (exp_v == h) ? 2'b10 : 2'b01;
        if (exp_v != 0) mf[exp_v+1] = 1'b0;
      end
      step(1);
      exp_v = model_pick(mf, en, prio, mn);
      chk("R5 random second", take_o, (exp_v >= 0) ? 1 : 0);
      if (exp_v >= 0) chk("R5 random second vec", vec_o, exp_v);
      tidy();
    end

    w0 = n_chk;
    if (w0 < 12) begin n_chk++; n_fail++; $display("FAIL count: actual %0d expected 12", w0); end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule